// File: doc/BRIEF.md
# Gated Pulse-Counting Frequency Meter

This block measures the frequency of a periodic digital signal by counting its rising edges during a gate window of fixed length. The window is timed from the system clock, whose rate is known. A start strobe opens one window. When the window closes, the edge count is latched into an output register and a one-cycle done pulse is raised. The frequency is the count divided by the window length. For example, 540 edges in a 10 ms window means a 54 kHz input.

A select input chooses between a short window and one ten times longer. The same source then gives about ten times the count. Resolution improves from one count per short window (100 Hz at 10 ms) to one count per long window (10 Hz at 100 ms), at the cost of a tenfold measurement time.

Control is a three-state machine:
- **IDLE** waits for `start`. On `start` it clears the edge counter, captures the window select and moves to GATE.
- **GATE** counts synchronized rising edges for exactly the selected number of clock cycles, then moves to LATCH.
- **LATCH** copies the count and overflow flag to the outputs, pulses `done` and returns to IDLE.

The input passes through a two-flop synchronizer before edge detection. The edge counter saturates at its maximum instead of wrapping, and an overflow flag records that it did.

Top module: `freq_meter`

## Requirements
- R1: While `rst_n` is low, `count_out`, `overflow` and `done` are 0. A reset during a window abandons it, and no `done` follows.
- R2: `count_out` equals the number of rising edges of `sig_in` seen after a two-flop synchronizer while the window was open. A constant input gives 0.
- R3: With `gate_long`=0 at start, the window lasts SHORT_CYC clock cycles. `done` is high in the cycle SHORT_CYC+2 clock cycles after the cycle in which `start` was sampled high.
- R4: With `gate_long`=1 at start, the window lasts LONG_CYC cycles. `done` follows after LONG_CYC+2 cycles.
- R5: `gate_long` is sampled only when a window opens. Changing it during the window does not change that window's length.
- R6: `done` is high for exactly one cycle per window. `count_out` and `overflow` change only in the cycle where `done` is high, and hold their values otherwise.
- R7: `start` is ignored while a window is open or being latched. It neither restarts nor extends the window.
- R8: The edge counter stops at 2^CNT_W−1. When an edge arrives at that value, `overflow` is reported as 1 for that window.
- R9: Each window starts from a count of zero, with `overflow` clear. Results from earlier windows do not carry over.
- R10: For a steady input, the long window's count is ten times the short window's count, within the ±1-edge quantization of each window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the time base for the window |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal to be measured |
| gate_long | input | 1 | Window select: 0 = short, 1 = ten-times-longer |
| start | input | 1 | Strobe that opens a window when idle |
| count_out | output | CNT_W | Latched edge count of the last window |
| overflow | output | 1 | Counter saturated during the last window |
| done | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The bench measures the cycles from `start` to `done` for both window lengths. A timer that is off by one, or that reads the select live, shows up as a wrong latency. This includes the case where `gate_long` is flipped or `start` is strobed again in the middle of a window. A toggling input drives the counter past its limit, so a wrapping counter would report a small count with no overflow flag. The following short window then catches a design that fails to clear the count or the flag. Other cases are a constant input (count 0), a reset in the middle of a window (which must not be followed by a stray `done`), and `count_out` held steady long after `done`, against a behavioural model checked on every clock.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_LATCH = 2'd2
    } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
// Multi-flop synchronizer followed by a rising-edge detector.
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fm_gate_timer.sv
// Counts system-clock cycles of the open window; length picked at load time.
module fm_gate_timer #(
    parameter int SHORT_CYC = 100,
    parameter int LONG_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic long_i,
    input  logic run_i,
    output logic last_o
);
    localparam int TMR_W = (LONG_CYC > 2) ? $clog2(LONG_CYC) : 1;
    localparam logic [TMR_W-1:0] SHORT_LAST = TMR_W'(SHORT_CYC - 1);
    localparam logic [TMR_W-1:0] LONG_LAST  = TMR_W'(LONG_CYC - 1);

    logic [TMR_W-1:0] tmr_q;
    logic             long_q;
    logic [TMR_W-1:0] end_v;

    assign end_v  = long_q ? LONG_LAST : SHORT_LAST;
    assign last_o = run_i && (tmr_q == end_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            long_q <= 1'b0;
        end else if (load_i) begin
            tmr_q  <= '0;
            long_q <= long_i;
        end else if (run_i && !last_o) begin
            tmr_q  <= tmr_q + 1'b1;
        end
    end

    // R3 / R4: the timer never runs past the selected window end
    a_r4_tmr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (tmr_q <= end_v));

    // R5: the captured select cannot move while the window runs
    a_r5_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(long_q));
endmodule

// File: rtl/fm_edge_counter.sv
// Saturating edge counter with sticky overflow flag.
module fm_edge_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             pulse_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (clr_i) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (en_i && pulse_i) begin
            if (cnt_o == CNT_MAX) begin
                ovf_o <= 1'b1;
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end

    // R8: an edge at full scale leaves the count at full scale and flags it
    a_r8_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && pulse_i && !clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX && ovf_o));

    // R9: a clear starts the window from nothing
    a_r9_clear_window: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0 && !ovf_o));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fm_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SHORT_CYC   = CLK_HZ / 100,
    parameter int LONG_CYC    = SHORT_CYC * 10,
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             gate_long,
    input  logic             start,
    output logic [CNT_W-1:0] count_out,
    output logic             overflow,
    output logic             done
);
    fm_state_e        state_q, state_d;
    logic             edge_rise;
    logic             arm;
    logic             counting;
    logic             gate_last;
    logic [CNT_W-1:0] edge_cnt;
    logic             edge_ovf;

    assign arm      = (state_q == ST_IDLE) && start;
    assign counting = (state_q == ST_GATE);

    fm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_in),
        .rise_o  (edge_rise)
    );

    fm_gate_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (arm),
        .long_i (gate_long),
        .run_i  (counting),
        .last_o (gate_last)
    );

    fm_edge_counter #(.CNT_W(CNT_W)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (arm),
        .en_i    (counting),
        .pulse_i (edge_rise),
        .cnt_o   (edge_cnt),
        .ovf_o   (edge_ovf)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_GATE;
            ST_GATE:  if (gate_last) state_d = ST_LATCH;
            ST_LATCH:                state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_out <= '0;
            overflow  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_LATCH) begin
                count_out <= edge_cnt;
                overflow  <= edge_ovf;
                done      <= 1'b1;
            end
        end
    end

    // R6: done never lasts two cycles
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the result moves only together with done
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(count_out) && $stable(overflow)));

    // R3: an open window stays open until the timer reaches its end
    a_r3_gate_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE && !gate_last) |=> (state_q == ST_GATE));

    // R7: a strobe during the window does not send the machine back to idle
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE && start && !gate_last) |=> (state_q == ST_GATE));
endmodule

// File: tb/freq_meter_tb_top.sv
module freq_meter_tb_top;
    localparam int CLK_HZ = 10_000;
    localparam int SHORT  = CLK_HZ / 100;
    localparam int LONG   = SHORT * 10;
    localparam int CW     = 8;
    localparam int MAXC   = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          gate_long = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] count_out;
    logic          overflow;
    logic          done;

    int n_chk = 0;
    int n_fail = 0;
    int half = 0;

    always #5 clk = ~clk;

    freq_meter #(.CLK_HZ(CLK_HZ), .CNT_W(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .gate_long (gate_long),
        .start     (start),
        .count_out (count_out),
        .overflow  (overflow),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Input waveform: toggles every 'half' cycles, frozen when half == 0
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (half > 0) begin
                ph++;
                if (ph >= half) begin
                    ph = 0;
                    sig_in = ~sig_in;
                end
            end
        end
    end

    // Behavioural reference model
    bit h1, h2, h3;
    int m_ph, m_t, m_c, m_of, m_lsel, m_res, m_ovf, m_done;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_ph = 0; m_t = 0; m_c = 0; m_of = 0; m_lsel = 0;
            m_res = 0; m_ovf = 0; m_done = 0;
        end else begin
            bit pulse;
            pulse = h2 && !h3;
            h3 = h2; h2 = h1; h1 = sig_in;
            m_done = 0;
            if (m_ph == 0) begin
                if (start) begin
                    m_ph = 1; m_t = 0; m_c = 0; m_of = 0; m_lsel = int'(gate_long);
                end
            end else if (m_ph == 1) begin
                if (pulse) begin
                    if (m_c == MAXC) m_of = 1;
                    else m_c++;
                end
                if (m_t == (m_lsel != 0 ? LONG : SHORT) - 1) m_ph = 2;
                else m_t++;
            end else begin
                m_res = m_c; m_ovf = m_of; m_done = 1; m_ph = 0;
            end
        end
    end

    // Per-clock comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(done == m_done[0], "R6", "done vs model", done, m_done);
                chk(int'(count_out) == m_res, "R2", "count_out vs model", count_out, m_res);
                chk(overflow == m_ovf[0], "R8", "overflow vs model", overflow, m_ovf);
            end
        end
    end

    // act: 0 none, 1 flip gate_long at cycle act_at, 2 strobe start at act_at
    task automatic run_window(input bit lg, input int act, input int act_at,
                              output int cyc, output int cnt, output bit ov);
        @(negedge clk);
        gate_long = lg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            if (act == 1 && cyc == act_at) gate_long = ~gate_long;
            if (act == 2 && cyc == act_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        cnt = int'(count_out);
        ov  = overflow;
        @(negedge clk);
        chk(done == 1'b0, "R6", "done width", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc, cnt_s, cnt_l, cnt;
        bit ov;

        // R1: outputs held low in reset
        repeat (4) @(negedge clk);
        chk(count_out == 0 && !overflow && !done, "R1", "reset outputs",
            {count_out, overflow, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2, R3: short window, period 4 -> about 25 edges
        half = 2;
        repeat (10) @(negedge clk);
        run_window(1'b0, 0, 0, cyc, cnt_s, ov);
        chk(cyc == SHORT + 2, "R3", "short latency", cyc, SHORT + 2);
        chk(cnt_s >= 24 && cnt_s <= 26, "R2", "short count", cnt_s, 25);

        // R4, R10: long window, same source
        run_window(1'b1, 0, 0, cyc, cnt_l, ov);
        chk(cyc == LONG + 2, "R4", "long latency", cyc, LONG + 2);
        chk(cnt_l >= 10 * cnt_s - 10 && cnt_l <= 10 * cnt_s + 10, "R10",
            "long/short ratio", cnt_l, 10 * cnt_s);

        // R5: select flipped during a short window
        run_window(1'b0, 1, 30, cyc, cnt, ov);
        chk(cyc == SHORT + 2, "R5", "select change mid-window", cyc, SHORT + 2);
        gate_long = 1'b0;

        // R7: second strobe during the window
        run_window(1'b0, 2, 50, cyc, cnt, ov);
        chk(cyc == SHORT + 2, "R7", "restart ignored", cyc, SHORT + 2);

        // R8: fastest input over the long window saturates
        half = 1;
        run_window(1'b1, 0, 0, cyc, cnt, ov);
        chk(cnt == MAXC, "R8", "saturated count", cnt, MAXC);
        chk(ov == 1'b1, "R8", "overflow flag", ov, 1);

        // R9: next short window starts clean
        run_window(1'b0, 0, 0, cyc, cnt, ov);
        chk(cnt >= 49 && cnt <= 51, "R9", "fresh count", cnt, 50);
        chk(ov == 1'b0, "R9", "overflow cleared", ov, 0);

        // R6: result held long after done
        repeat (20) @(negedge clk);
        chk(int'(count_out) == cnt, "R6", "result held", count_out, cnt);

        // R2: constant input gives zero
        half = 0;
        repeat (5) @(negedge clk);
        run_window(1'b0, 0, 0, cyc, cnt, ov);
        chk(cnt == 0, "R2", "constant input", cnt, 0);

        // R1: reset in the middle of a window
        half = 2;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(count_out == 0 && !overflow && !done, "R1", "mid-window reset",
            {count_out, overflow, done}, 0);
        rst_n = 1'b1;
        begin
            int seen = 0;
            repeat (SHORT + 10) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk(seen == 0, "R1", "no done after abandoned window", seen, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule